// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that opens a bank of ten 8-bit registers to a bus host. SCL and SDA are sampled on the system clock through two-flop synchronisers. Edge detection on the synchronised lines finds START, STOP and SCL edges. A 7-bit device address, set by a parameter, is compared against the first byte of every transaction. The block signals an acknowledge or sends a zero bit by pulling SDA low through an active-high drive output. The pad and its pull-up sit outside the block.

In a write transaction, the first byte after the address goes into a control byte. Its low nibble is a register index and bit 4 is an auto-increment enable. Later bytes are written to the indexed register. A read, whether in a fresh transaction or after a repeated START, returns data starting at the current index. Indices 0 and 1 reflect two external input bytes. Indices 2 to 9 are writable storage, and their contents appear on a flat output bus.

Top module: `i2cp_target`

## Requirements
- R1: After reset, SDA is released, all writable registers read 0x00, and the control byte is 0x00 (index 0, auto-increment off).
- R2: The block pulls SDA low during the ninth SCL pulse of an address byte only when the byte's upper 7 bits equal DEV_ADDR. On a mismatch it drives nothing until the next START or STOP.
- R3: In a write transaction, every data byte is acknowledged, including bytes sent to read-only or unused indices.
- R4: The first byte written after the address is stored as the control byte. Bits [3:0] are the register index and bit 4 is the auto-increment flag.
- R5: Index 0 reads ro_bytes_i[7:0] and index 1 reads ro_bytes_i[15:8]. Index k (2..9) is stored storage visible on rw_bytes_o[8*(k-2)+7 : 8*(k-2)].
- R6: Writes to indices 0, 1 and 10..15 change no register. Reads of indices 10..15 return 0x00.
- R7: With auto-increment set, the index advances by one after each data byte written or read. From 9 or any higher index it goes to 0.
- R8: With auto-increment clear, every data byte of a transaction accesses the same register.
- R9: Read data leaves MSB first. After a master ACK in the ninth pulse, the next byte follows.
- R10: After a master NACK on a read byte, SDA stays released through any further SCL activity until STOP or START.
- R11: A read begins at the current index. A repeated START does not modify the index.
- R12: The SDA drive output changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ro_bytes_i | input | 16 | Read-only bytes for indices 0 (low) and 1 (high) |
| rw_bytes_o | output | 64 | Writable registers 2..9, index 2 in the low byte |

## Verification
The bench sweeps all sixteen index values for both writes and reads. A design that decoded the index wrongly or let read-only or unused slots be written would return wrong bytes or disturb the output bus. Auto-increment runs are started at indices 2, 8 and 14, so a wrap taken at 15 or at 10 instead of after 9 shows up as a shifted read stream. A mismatched address is followed by a whole data byte, and a NACKed read is followed by extra pulses. A design that kept answering would pull SDA low where the bench expects it high. Reads are started both through a repeated START and in a fresh transaction after a write left the index elsewhere, which catches a pointer reset on START.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int BYTE_W       = 8;
    localparam int IDX_W        = 4;
    localparam int AI_POS       = 4;
    localparam int DEF_NUM_REGS = 10;
    localparam int DEF_NUM_RO   = 2;
    localparam logic [6:0] DEF_DEV_ADDR = 7'h60;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_HOLD
    } link_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic              valid;
        logic              first;
        logic [BYTE_W-1:0] data;
    } wr_evt_t;

    function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] idx,
                                                    input logic [IDX_W-1:0] last);
        return (idx >= last) ? '0 : idx + 1'b1;
    endfunction

endpackage

// File: rtl/i2cp_sync.sv
module i2cp_sync
    import i2cp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic [1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 2'b11;
        else     prev <= synced;
    end

    // synced[1] is SCL, synced[0] is SDA
    assign evt.scl   = synced[1];
    assign evt.sda   = synced[0];
    assign evt.rise  = synced[1] & ~prev[1];
    assign evt.fall  = ~synced[1] & prev[1];
    assign evt.start = synced[1] & prev[1] & prev[0] & ~synced[0];
    assign evt.stop  = synced[1] & prev[1] & ~prev[0] & synced[0];

endmodule

// File: rtl/i2cp_link.sv
module i2cp_link
    import i2cp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_low,
    output wr_evt_t           wr_o,
    output logic              rd_done,
    output logic              hold
);
    link_state_e       state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sh;
    logic              is_read;
    logic              first;
    logic              ack_ok;

    assign hold = (state == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            is_read <= 1'b0;
            first   <= 1'b0;
            ack_ok  <= 1'b0;
            sda_low <= 1'b0;
            wr_o    <= '0;
            rd_done <= 1'b0;
        end else begin
            wr_o.valid <= 1'b0;
            rd_done    <= 1'b0;
            if (evt.start) begin
                state   <= ST_ADDR;
                cnt     <= '0;
                sda_low <= 1'b0;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (evt.rise) begin
                            sh  <= {sh[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt.fall && cnt == 4'd8) begin
                            if (sh[7:1] == DEV_ADDR) begin
                                sda_low <= 1'b1;
                                is_read <= sh[0];
                                state   <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.fall) begin
                            cnt <= '0;
                            if (is_read) begin
                                sh      <= rd_data;
                                sda_low <= ~rd_data[BYTE_W-1];
                                state   <= ST_RD;
                            end else begin
                                sda_low <= 1'b0;
                                first   <= 1'b1;
                                state   <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (evt.rise) begin
                            sh  <= {sh[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt.fall && cnt == 4'd8) begin
                            wr_o    <= '{valid: 1'b1, first: first, data: sh};
                            sda_low <= 1'b1;
                            state   <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.fall) begin
                            sda_low <= 1'b0;
                            cnt     <= '0;
                            first   <= 1'b0;
                            state   <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (evt.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt.fall) begin
                            if (cnt == 4'd8) begin
                                sda_low <= 1'b0;
                                rd_done <= 1'b1;
                                state   <= ST_RD_ACK;
                            end else begin
                                sh      <= {sh[BYTE_W-2:0], 1'b0};
                                sda_low <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.rise) begin
                            ack_ok <= ~evt.sda;
                        end else if (evt.fall) begin
                            if (ack_ok) begin
                                sh      <= rd_data;
                                sda_low <= ~rd_data[BYTE_W-1];
                                cnt     <= '0;
                                state   <= ST_RD;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cp_regfile.sv
module i2cp_regfile
    import i2cp_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int NUM_RO   = DEF_NUM_RO
) (
    input  logic                                clk,
    input  logic                                rst,
    input  wr_evt_t                             wr,
    input  logic                                rd_done,
    input  logic [NUM_RO*BYTE_W-1:0]            ro_bytes,
    output logic [(NUM_REGS-NUM_RO)*BYTE_W-1:0] rw_bytes,
    output logic [BYTE_W-1:0]                   ctrl,
    output logic [BYTE_W-1:0]                   rd_data
);
    localparam int NUM_RW = NUM_REGS - NUM_RO;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    logic [IDX_W-1:0] idx;
    logic             ai;

    assign idx = ctrl[IDX_W-1:0];
    assign ai  = ctrl[AI_POS];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr.valid && wr.first) begin
            ctrl <= wr.data;
        end else if ((wr.valid || rd_done) && ai) begin
            ctrl[IDX_W-1:0] <= next_index(idx, LAST_IDX);
        end
    end

    for (genvar k = 0; k < NUM_RW; k++) begin : g_rw
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr.valid && !wr.first && idx == IDX_W'(k + NUM_RO)) begin
                q <= wr.data;
            end
        end
        assign rw_bytes[k*BYTE_W +: BYTE_W] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_RO; k++) begin
            if (idx == IDX_W'(k)) rd_data = ro_bytes[k*BYTE_W +: BYTE_W];
        end
        for (int k = 0; k < NUM_RW; k++) begin
            if (idx == IDX_W'(k + NUM_RO)) rd_data = rw_bytes[k*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/i2cp_target.sv
module i2cp_target
    import i2cp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR,
    parameter int         NUM_REGS = DEF_NUM_REGS,
    parameter int         NUM_RO   = DEF_NUM_RO,
    parameter int         STAGES   = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                scl_i,
    input  logic                                sda_i,
    output logic                                sda_low_o,
    input  logic [NUM_RO*BYTE_W-1:0]            ro_bytes_i,
    output logic [(NUM_REGS-NUM_RO)*BYTE_W-1:0] rw_bytes_o
);
    bus_evt_t          bus_evt;
    wr_evt_t           wr_evt;
    logic              rd_done;
    logic              link_hold;
    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] rd_data;

    i2cp_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (bus_evt)
    );

    i2cp_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk     (clk),
        .rst     (rst),
        .evt     (bus_evt),
        .rd_data (rd_data),
        .sda_low (sda_low_o),
        .wr_o    (wr_evt),
        .rd_done (rd_done),
        .hold    (link_hold)
    );

    i2cp_regfile #(.NUM_REGS(NUM_REGS), .NUM_RO(NUM_RO)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_evt),
        .rd_done  (rd_done),
        .ro_bytes (ro_bytes_i),
        .rw_bytes (rw_bytes_o),
        .ctrl     (ctrl_q),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/i2cp_target_chk.sv
module i2cp_target_chk
    import i2cp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_lvl,
    input logic              sda_low,
    input logic              hold,
    input logic              rd_done,
    input wr_evt_t           wr,
    input logic [BYTE_W-1:0] ctrl
);
    logic adv;
    assign adv = rd_done || (wr.valid && !wr.first);

    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_low)); // R12

    AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        hold |-> !sda_low); // R10

    AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && wr.first) |=> (ctrl == $past(wr.data))); // R4

    AST_AI_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && ctrl[AI_POS] && ctrl[IDX_W-1:0] >= 4'd9) |=> (ctrl[IDX_W-1:0] == 4'd0)); // R7

    AST_NO_AI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (adv && !ctrl[AI_POS]) |=> $stable(ctrl)); // R8

endmodule

bind i2cp_target i2cp_target_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_lvl (bus_evt.scl),
    .sda_low (sda_low_o),
    .hold    (link_hold),
    .rd_done (rd_done),
    .wr      (wr_evt),
    .ctrl    (ctrl_q)
);

// File: tb/i2cp_target_tb.sv
module i2cp_target_tb;
    localparam int Q = 8;
    localparam logic [7:0] AW = 8'hC0;   // address 0x60, write
    localparam logic [7:0] AR = 8'hC1;   // address 0x60, read

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_low;
    logic        sda_line;
    logic [15:0] ro_bytes = 16'hB7A5;
    logic [63:0] rw_bytes;

    int checks = 0;
    int errors = 0;
    int viol   = 0;
    logic [7:0] model [16];
    logic [3:0] mptr = 4'd0;
    logic       mai  = 1'b0;

    always #10 clk = ~clk;
    assign sda_line = ~(m_low | sda_low);

    i2cp_target u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_low_o  (sda_low),
        .ro_bytes_i (ro_bytes),
        .rw_bytes_o (rw_bytes)
    );

    // R12 monitor at the ports
    logic prev_scl = 1'b1, prev_low = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_m && prev_scl && sda_low !== prev_low) viol++;
        prev_scl = scl_m;
        prev_low = sda_low;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] i);
        if (i == 4'd0) return ro_bytes[7:0];
        if (i == 4'd1) return ro_bytes[15:8];
        if (i <= 4'd9) return model[i];
        return 8'h00;
    endfunction

    function automatic logic [3:0] step(input logic [3:0] i, input logic ai);
        if (!ai) return i;
        return (i >= 4'd9) ? 4'd0 : i + 4'd1;
    endfunction

    function automatic logic [63:0] exp_rw();
        logic [63:0] v;
        for (int k = 2; k < 10; k++) v[(k-2)*8 +: 8] = model[k];
        return v;
    endfunction

    task automatic i2c_start();
        m_low = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        m_low = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        m_low = 1'b0; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        m_low = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = (sda_line == 1'b0);
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            d[i] = sda_line;
            wq(Q);
            scl_m = 1'b0;
        end
        m_low = give_ack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        m_low = 1'b0;
    endtask

    // write control byte plus n data bytes, updating the bench model
    task automatic wr_txn(input logic [7:0] ctrl, input int n, input logic [7:0] d [8],
                          input string req);
        logic ack;
        i2c_start();
        write_byte(AW, ack);  chk({req, " addr ack R2"}, ack, 1'b1);
        write_byte(ctrl, ack); chk({req, " ctrl ack R3"}, ack, 1'b1);
        mptr = ctrl[3:0];
        mai  = ctrl[4];
        for (int i = 0; i < n; i++) begin
            write_byte(d[i], ack);
            chk({req, " data ack R3"}, ack, 1'b1);
            if (mptr >= 4'd2 && mptr <= 4'd9) model[mptr] = d[i];
            mptr = step(mptr, mai);
        end
        i2c_stop();
    endtask

    // optional control write, then (repeated) start read of n bytes
    task automatic rd_txn(input logic set_ctrl, input logic [7:0] ctrl, input int n,
                          input logic hold_test, input string req);
        logic ack;
        logic [7:0] d;
        i2c_start();
        if (set_ctrl) begin
            write_byte(AW, ack);   chk({req, " addr ack R2"}, ack, 1'b1);
            write_byte(ctrl, ack); chk({req, " ctrl ack R3"}, ack, 1'b1);
            mptr = ctrl[3:0];
            mai  = ctrl[4];
            i2c_start();
        end
        write_byte(AR, ack); chk({req, " read addr ack R2"}, ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, d);
            chk({req, " data R9"}, d, exp_read(mptr));
            mptr = step(mptr, mai);
        end
        if (hold_test) begin
            int lows = 0;
            for (int i = 0; i < 9; i++) begin
                m_low = 1'b0; wq(Q);
                scl_m = 1'b1;
                for (int j = 0; j < 2*Q; j++) begin
                    wq(1);
                    if (sda_low) lows++;
                end
                scl_m = 1'b0; wq(Q);
            end
            chk("R10 silent after NACK", lows, 0);
        end
        i2c_stop();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run did not complete");
        summary();
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d [8];
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        wq(5);
        rst = 1'b0;
        wq(5);

        // R1 reset state
        chk("R1 sda released", sda_low, 1'b0);
        chk("R1 rw regs zero", rw_bytes, 64'h0);
        rd_txn(1'b0, 8'h00, 2, 1'b0, "R1 control zero, R8 no step");

        // R2 wrong address, no answer to address or data
        i2c_start();
        write_byte(8'hC4, ack); chk("R2 mismatch addr", ack, 1'b0);
        write_byte(8'h00, ack); chk("R2 mismatch data", ack, 1'b0);
        i2c_stop();

        // R4 R5 R7 write run from index 2 with auto-increment
        for (int i = 0; i < 8; i++) d[i] = 8'(8'h11 * (i + 1));
        wr_txn(8'h12, 8, d, "R7 run");
        chk("R5 rw mapping", rw_bytes, exp_rw());

        // R7 wrap across 9 to 0, R6 discard on 0 and 1
        for (int i = 0; i < 8; i++) d[i] = 8'(8'hC0 + i);
        wr_txn(8'h18, 5, d, "R7 wrap");
        chk("R7 wrap write, R6 discard", rw_bytes, exp_rw());

        // R8 no auto-increment
        for (int i = 0; i < 8; i++) d[i] = 8'(8'h5A ^ i);
        wr_txn(8'h05, 3, d, "R8 hold");
        chk("R8 same register", rw_bytes, exp_rw());

        // R6 unused index write
        wr_txn(8'h0C, 2, d, "R6 unused write");
        chk("R6 unused write discarded", rw_bytes, exp_rw());

        // R11 R9 R7 read through repeated start, wrap, then R10 hold
        rd_txn(1'b1, 8'h10, 11, 1'b1, "R11 R7 read wrap");
        // R2 still answers after hold and stop
        rd_txn(1'b1, 8'h03, 3, 1'b0, "R8 read no step");

        // R11 fresh read continues at index left by a write
        for (int i = 0; i < 8; i++) d[i] = 8'(8'h90 + i);
        wr_txn(8'h16, 1, d, "R11 setup");
        rd_txn(1'b0, 8'h00, 3, 1'b0, "R11 fresh read");

        // R6 reads of unused indices, auto-increment from 14
        rd_txn(1'b1, 8'h1E, 3, 1'b0, "R6 unused read");

        // sweep all indices: write then read
        for (int i = 0; i < 16; i++) begin
            d[0] = 8'((i * 37 + 5) & 8'hFF);
            wr_txn(8'(i), 1, d, "R5 sweep write");
        end
        chk("R5 sweep rw bus", rw_bytes, exp_rw());
        ro_bytes = 16'h3C96;
        for (int i = 0; i < 16; i++) begin
            rd_txn(1'b1, 8'(i), 1, 1'b0, "R5 R6 sweep read");
        end

        chk("R12 drive stable while SCL high", viol, 0);
        summary();
        $finish;
    end

endmodule